// File: doc/BRIEF.md
# Debug Instruction Side-Effect Decoder

This block sits behind the instruction register of a JTAG test access port. Each time the TAP issues its update strobe, the block decodes the new instruction code. The decoded code turns into control requests for the processor core. One pair of codes drives a chip-level debug reset that behaves like a power-on reset. Once that reset is released, the core starts fetching from its power-on vector; the fetch itself is outside this block. Other codes raise a debug interrupt at the top priority level, select bypass mode for the debug pins, or wake the core from sleep.

The block only produces these requests and holds them as long as they should be held. Shifting the instruction register has no effect. Only the update strobe counts. Power-mode status inputs gate the interrupt and the wakeup. An acknowledge input from the core retires the interrupt. A test-logic-reset indication from the TAP clears bypass.

Top module: `jtag_cmd_decoder`

## Requirements
- R1: After the power-on reset input `rstN` is released, `dbgReset`, `irqReq`, `bypassEn` and `wakePulse` are 0 and `irqLevel` is 0.
- R2: When `irUpdate` is high with code 4'b0010 (reset assert), `dbgReset` is 1 from the next cycle on. It stays 1 through any number of cycles and other commands until a reset-negate command arrives.
- R3: When `irUpdate` is high with code 4'b0011 (reset negate), `dbgReset` is 0 from the next cycle on.
- R4: When `irUpdate` is high with code 4'b0101 (interrupt) and neither `sleepMode` nor `standbyMode` is high, `irqReq` is 1 in the next cycle. While `irqReq` is 1, `irqLevel` reads 15. While it is 0, `irqLevel` reads 0.
- R5: `irqReq` stays 1 until a cycle with `irqAck` high, and it is 0 after that cycle. Repeated interrupt commands do not queue: a single acknowledge clears them all. If an acknowledge and an accepted interrupt command come in the same cycle, the request stays 1.
- R6: An interrupt command that arrives while `sleepMode` or `standbyMode` is high is dropped. It does not raise `irqReq`, either at that point or after the core leaves the low-power mode.
- R7: When `irUpdate` is high with code 4'b1111 (bypass), `bypassEn` is 1 from the next cycle on. Any other recognised code (0001, 0010, 0011, 0101) loaded later clears it.
- R8: When `tlrActive` is high, `bypassEn` is 0 in the next cycle, even if a bypass command arrives in the same cycle.
- R9: When `irUpdate` is high with code 4'b0001 (wake) and `sleepMode` is high, `wakePulse` is 1 for exactly the next cycle. The same code without `sleepMode` gives no pulse.
- R10: An update with any unrecognised code leaves `dbgReset`, `irqReq` and `bypassEn` unchanged and gives no wake pulse.
- R11: While `irUpdate` is low, the value of `irValue` changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset, synchronous |
| tlrActive | input | 1 | TAP is in test-logic-reset |
| irValue | input | IR_W (4) | Instruction register contents |
| irUpdate | input | 1 | Instruction register update strobe |
| sleepMode | input | 1 | Core is in sleep mode |
| standbyMode | input | 1 | Core is in standby mode |
| irqAck | input | 1 | Core accepted the debug interrupt |
| dbgReset | output | 1 | Debug chip reset level |
| irqReq | output | 1 | Debug interrupt request |
| irqLevel | output | LVL_W (4) | Priority level of the request |
| bypassEn | output | 1 | Debug-pin bypass select |
| wakePulse | output | 1 | One-cycle sleep wakeup request |

## Verification
The bench builds the block with its default parameters: a 4-bit instruction register, a 4-bit level field, an interrupt level of 15, and the code set listed in the requirements. With these values, every code a 4-bit register can hold is reachable. So the bench can feed recognised codes, unused codes and the fixed wake code through the same path and check the outputs against its own model. It also drives the same-cycle collisions that the requirements settle: acknowledge against a new interrupt, and test-logic reset against a bypass load.

// File: rtl/jcd_pkg.sv
package jcd_pkg;
  typedef struct packed {
    logic rstSet;
    logic rstClr;
    logic irqSet;
    logic bypSet;
    logic bypClr;
    logic wake;
  } cmdStrobes_t;
endpackage

// File: rtl/jcd_ctrl.sv
module jcd_ctrl
  import jcd_pkg::*;
#(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] CODE_WAKE = 'b0001,
  parameter logic [IR_W-1:0] CODE_RST_ON = 'b0010,
  parameter logic [IR_W-1:0] CODE_RST_OFF = 'b0011,
  parameter logic [IR_W-1:0] CODE_IRQ = 'b0101,
  parameter logic [IR_W-1:0] CODE_BYP = 'b1111
) (
  input  logic [IR_W-1:0] irValue,
  input  logic            irUpdate,
  input  logic            sleepMode,
  input  logic            standbyMode,
  output cmdStrobes_t     strb
);
  logic isWake, isRstOn, isRstOff, isIrq, isByp, isKnown, lowPower;

  always_comb begin
    isWake   = (irValue == CODE_WAKE);
    isRstOn  = (irValue == CODE_RST_ON);
    isRstOff = (irValue == CODE_RST_OFF);
    isIrq    = (irValue == CODE_IRQ);
    isByp    = (irValue == CODE_BYP);
    isKnown  = isWake | isRstOn | isRstOff | isIrq | isByp;
    lowPower = sleepMode | standbyMode;

    strb.rstSet = irUpdate & isRstOn;
    strb.rstClr = irUpdate & isRstOff;
    // interrupt commands in a low-power mode are dropped outright (R6)
    strb.irqSet = irUpdate & isIrq & ~lowPower;
    strb.bypSet = irUpdate & isByp;
    strb.bypClr = irUpdate & isKnown & ~isByp;
    strb.wake   = irUpdate & isWake & sleepMode;
  end
endmodule

// File: rtl/jcd_datapath.sv
module jcd_datapath
  import jcd_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int IRQ_LEVEL = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tlrActive,
  input  logic             irqAck,
  input  cmdStrobes_t      strb,
  output logic             dbgReset,
  output logic             irqReq,
  output logic [LVL_W-1:0] irqLevel,
  output logic             bypassEn,
  output logic             wakePulse
);
  localparam logic [LVL_W-1:0] LVL = LVL_W'(IRQ_LEVEL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbgReset  <= 1'b0;
      irqReq    <= 1'b0;
      bypassEn  <= 1'b0;
      wakePulse <= 1'b0;
    end else begin
      if (strb.rstSet)      dbgReset <= 1'b1;
      else if (strb.rstClr) dbgReset <= 1'b0;

      irqReq <= (irqReq & ~irqAck) | strb.irqSet;

      if (tlrActive)        bypassEn <= 1'b0;
      else if (strb.bypSet) bypassEn <= 1'b1;
      else if (strb.bypClr) bypassEn <= 1'b0;

      wakePulse <= strb.wake;
    end
  end

  assign irqLevel = irqReq ? LVL : '0;

  p_rst_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rstSet && !strb.rstClr) |=> $stable(dbgReset));
  p_irq_pending_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> irqReq);
  p_tlr_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    tlrActive |=> !bypassEn);
  p_wake_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wake |=> !wakePulse);
endmodule

// File: rtl/jtag_cmd_decoder.sv
module jtag_cmd_decoder
  import jcd_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int LVL_W = 4,
  parameter int IRQ_LEVEL = 15,
  parameter logic [IR_W-1:0] CODE_WAKE = 'b0001,
  parameter logic [IR_W-1:0] CODE_RST_ON = 'b0010,
  parameter logic [IR_W-1:0] CODE_RST_OFF = 'b0011,
  parameter logic [IR_W-1:0] CODE_IRQ = 'b0101,
  parameter logic [IR_W-1:0] CODE_BYP = 'b1111
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tlrActive,
  input  logic [IR_W-1:0]  irValue,
  input  logic             irUpdate,
  input  logic             sleepMode,
  input  logic             standbyMode,
  input  logic             irqAck,
  output logic             dbgReset,
  output logic             irqReq,
  output logic [LVL_W-1:0] irqLevel,
  output logic             bypassEn,
  output logic             wakePulse
);
  cmdStrobes_t strb;

  jcd_ctrl #(
    .IR_W(IR_W), .CODE_WAKE(CODE_WAKE), .CODE_RST_ON(CODE_RST_ON),
    .CODE_RST_OFF(CODE_RST_OFF), .CODE_IRQ(CODE_IRQ), .CODE_BYP(CODE_BYP)
  ) u_ctrl (
    .irValue(irValue), .irUpdate(irUpdate), .sleepMode(sleepMode),
    .standbyMode(standbyMode), .strb(strb)
  );

  jcd_datapath #(.LVL_W(LVL_W), .IRQ_LEVEL(IRQ_LEVEL)) u_dp (
    .clk(clk), .rstN(rstN), .tlrActive(tlrActive), .irqAck(irqAck),
    .strb(strb), .dbgReset(dbgReset), .irqReq(irqReq), .irqLevel(irqLevel),
    .bypassEn(bypassEn), .wakePulse(wakePulse)
  );

  logic unknownCode;
  assign unknownCode = (irValue != CODE_WAKE) && (irValue != CODE_RST_ON) &&
                       (irValue != CODE_RST_OFF) && (irValue != CODE_IRQ) &&
                       (irValue != CODE_BYP);

  p_irq_dropped_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irUpdate && irValue == CODE_IRQ && (sleepMode || standbyMode) && !irqReq)
      |=> !irqReq);
  p_unknown_inert_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irUpdate && unknownCode && !tlrActive && !irqAck)
      |=> ($stable(dbgReset) && $stable(irqReq) && $stable(bypassEn) && !wakePulse));
  p_no_strobe_inert_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!irUpdate && !tlrActive && !irqAck)
      |=> ($stable(dbgReset) && $stable(irqReq) && $stable(bypassEn) && !wakePulse));
endmodule

// File: tb/jtag_cmd_decoder_test.sv
module jtag_cmd_decoder_test;
  localparam logic [3:0] C_WAKE = 4'b0001, C_RON = 4'b0010, C_ROFF = 4'b0011,
                         C_IRQ = 4'b0101, C_BYP = 4'b1111;

  logic clk = 1'b0, rstN = 1'b0, tlrActive = 1'b0, irUpdate = 1'b0;
  logic sleepMode = 1'b0, standbyMode = 1'b0, irqAck = 1'b0;
  logic [3:0] irValue = 4'b0000;
  logic dbgReset, irqReq, bypassEn, wakePulse;
  logic [3:0] irqLevel;

  always #10 clk = ~clk;

  jtag_cmd_decoder uut (
    .clk(clk), .rstN(rstN), .tlrActive(tlrActive), .irValue(irValue),
    .irUpdate(irUpdate), .sleepMode(sleepMode), .standbyMode(standbyMode),
    .irqAck(irqAck), .dbgReset(dbgReset), .irqReq(irqReq), .irqLevel(irqLevel),
    .bypassEn(bypassEn), .wakePulse(wakePulse)
  );

  typedef struct {
    int         due;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0, checks = 0, errors = 0;
  logic mRst = 0, mIrq = 0, mByp = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pack(logic r, logic i, logic [3:0] l, logic b, logic w);
    return {r, i, l, b, w};
  endfunction

  // monitor: compares scoreboard items that fall due at this sampling point
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it  = sbq.pop_front();
      act = pack(dbgReset, irqReq, irqLevel, bypassEn, wakePulse);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %b expected %b (rst irq lvl[4] byp wake)", it.tag, act, it.exp);
      end
    end
  end

  // driver: applies one cycle of stimulus and pushes the model's expectation
  task automatic step(input logic upd, input logic [3:0] code, input logic slp,
                      input logic stb, input logic ack, input logic tlr, input string tag);
    logic wk;
    item_t it;
    @(negedge clk);
    irUpdate = upd; irValue = code; sleepMode = slp; standbyMode = stb;
    irqAck = ack; tlrActive = tlr;
    if (upd && code == C_RON) mRst = 1;
    else if (upd && code == C_ROFF) mRst = 0;
    mIrq = (mIrq & ~ack) | (upd && code == C_IRQ && !slp && !stb);
    if (tlr) mByp = 0;
    else if (upd && (code == C_WAKE || code == C_RON || code == C_ROFF ||
                     code == C_IRQ || code == C_BYP)) mByp = (code == C_BYP);
    wk = upd && code == C_WAKE && slp;
    it.due = cyc + 1;
    it.exp = pack(mRst, mIrq, mIrq ? 4'd15 : 4'd0, mByp, wk);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if ({dbgReset, irqReq, irqLevel, bypassEn, wakePulse} !== 8'b0) begin
      errors++;
      $display("FAIL R1: actual %b expected 00000000",
               {dbgReset, irqReq, irqLevel, bypassEn, wakePulse});
    end
    // R11: codes present on irValue without update strobe
    step(0, C_RON, 0, 0, 0, 0, "R11 no strobe reset code");
    step(0, C_BYP, 1, 0, 0, 0, "R11 no strobe bypass code");
    step(0, C_WAKE, 1, 0, 0, 0, "R11 no strobe wake code");
    // R2, R3 reset pair
    step(1, C_RON, 0, 0, 0, 0, "R2 reset assert");
    step(0, 4'h0, 0, 0, 0, 0, "R2 reset held");
    step(1, 4'b0110, 0, 0, 0, 0, "R10 unknown code during reset");
    step(1, C_IRQ, 0, 0, 0, 0, "R2 reset held through interrupt");
    step(0, 4'h0, 0, 0, 1, 0, "R5 ack clears");
    step(1, C_ROFF, 0, 0, 0, 0, "R3 reset negate");
    step(0, 4'h0, 0, 0, 0, 0, "R3 reset stays off");
    // R4, R5 interrupt
    step(1, C_IRQ, 0, 0, 0, 0, "R4 interrupt raised level 15");
    step(1, C_IRQ, 0, 0, 0, 0, "R5 second interrupt command");
    step(0, 4'h0, 0, 0, 0, 0, "R5 pending without ack");
    step(0, 4'h0, 0, 0, 1, 0, "R5 single ack clears all");
    step(0, 4'h0, 0, 0, 0, 0, "R5 nothing queued");
    step(1, C_IRQ, 0, 0, 0, 0, "R4 interrupt again");
    step(1, C_IRQ, 0, 0, 1, 0, "R5 ack with new command keeps request");
    step(0, 4'h0, 0, 0, 1, 0, "R5 final ack");
    // R6 low-power drop
    step(1, C_IRQ, 1, 0, 0, 0, "R6 interrupt in sleep dropped");
    step(0, 4'h0, 0, 0, 0, 0, "R6 not raised after sleep");
    step(1, C_IRQ, 0, 1, 0, 0, "R6 interrupt in standby dropped");
    step(0, 4'h0, 0, 0, 0, 0, "R6 not raised after standby");
    // R7, R8 bypass
    step(1, C_BYP, 0, 0, 0, 0, "R7 bypass set");
    step(1, 4'b1010, 0, 0, 0, 0, "R10 unknown keeps bypass");
    step(0, 4'h0, 0, 0, 0, 0, "R7 bypass held");
    step(1, C_RON, 0, 0, 0, 0, "R7 other code clears bypass");
    step(1, C_ROFF, 0, 0, 0, 0, "R3 negate after bypass");
    step(1, C_BYP, 0, 0, 0, 0, "R7 bypass set again");
    step(0, 4'h0, 0, 0, 0, 1, "R8 test-logic reset clears bypass");
    step(1, C_BYP, 0, 0, 0, 1, "R8 bypass load with test-logic reset");
    step(1, C_BYP, 0, 0, 0, 0, "R7 bypass before wake");
    // R9 wakeup
    step(1, C_WAKE, 1, 0, 0, 0, "R9 wake in sleep pulses, clears bypass");
    step(0, 4'h0, 1, 0, 0, 0, "R9 pulse lasts one cycle");
    step(1, C_WAKE, 0, 0, 0, 0, "R9 no pulse when awake");
    step(1, C_WAKE, 0, 1, 0, 0, "R9 no pulse in standby");
    step(1, 4'b1000, 1, 0, 0, 0, "R10 unknown in sleep no pulse");
    step(0, 4'h0, 0, 0, 0, 0, "R1 idle tail");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule